// File: doc/BRIEF.md
# Four-Output Pulse Width Modulation Generator

This block produces four pulse width modulated outputs. The outputs are grouped as two pairs and all four share one period counter. Software sets a control word, a period and four duty values through a small write port. In edge mode the counter runs upward and wraps. In center mode it runs up and then back down, which gives pulses that are symmetric about the start of each period. Either pair can be switched to complementary operation, in which the odd output is the inverse of the even one. Otherwise each output follows its own duty value.

Every programmable value goes first into a staging copy. It becomes active only at a reload point, so a waveform never changes partway through a period. In center mode a double-update option adds a second reload point for the duty values, half-way through the period. The sync output pulses for one cycle at each reload point. Deasserting the global enable drives all outputs low and holds the counter at its start. While the enable is low, staged values pass to the active copy on every cycle, so software can program the block and then start it in a known state.

Top module: `pwm_quad_gen`

## Requirements
- R1: While reset is asserted, and after it until the block is enabled, every output and the sync pulse are low. After reset the period is 16 and all duties and control bits are 0.
- R2: Edge mode (control bit 0 clear): the counter steps 0 to P-1 and wraps. For duty D with 0<D<P, the output is high for the first D of every P cycles.
- R3: Center mode (control bit 0 set): the counter steps up from 0 to P and then down to 1, so one period is 2P cycles. The output is high while the count is below D, which gives 2D-1 high cycles per period for 0<D<P.
- R4: When control bit 2 (pair 0) or bit 3 (pair 1) is set, output 1 (or output 3) is the inverse of output 0 (or output 2), and the duty written for the odd output has no effect.
- R5: When the pair bit is clear, each of the four outputs follows its own duty value, at addresses 2 to 5 for outputs 0 to 3.
- R6: A duty of 0 keeps the output low for the whole period. A duty at or above the period keeps it high for the whole period, without a gap at the turnaround.
- R7: A write to the control word (address 0), the period (address 1) or a duty register changes nothing until the next reload point. Addresses 6 and 7 are ignored.
- R8: In center mode with control bit 1 set, duty values also reload at the top of the count. Period and control reload only at the period start. This gives two sync pulses per period, against one in single-update mode.
- R9: The sync pulse is high for exactly one cycle, the cycle after each reload edge. Outputs are registered, so they show the new values one cycle after the sync pulse.
- R10: While the enable is low, outputs and sync are low in the next cycle, the counter is held at 0 counting up, and staged values are copied to the active set on every cycle.
- R11: A period written below 2 is stored as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 period, 2-5 duty) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 4 | PWM outputs |
| sync_pulse | output | 1 | One-cycle reload marker |

## Verification
A write presented at a falling edge reaches its staging register at the next rising edge. It only shows on the pins after the next reload edge, when sync rises in that cycle, and the outputs follow one cycle later. The bench therefore waits for a fresh sync pulse at least one full cycle after each write before it counts a period. It then samples the outputs on the falling edges that follow the sync pulse, starting with the first: these samples match counter values 0 up to L-1. A cycle-stepped bench model also compares both outputs on every falling edge, and directed counts of high cycles and sync pulses confirm the duty, alignment and reload rules.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  // register addresses
  localparam int A_CTRL   = 0;
  localparam int A_PERIOD = 1;
  localparam int A_DUTY0  = 2;
  // control word bit positions
  localparam int CB_CENTER = 0;
  localparam int CB_DOUBLE = 1;
  localparam int CB_COMP0  = 2;
  // smallest usable period
  localparam int MIN_PERIOD = 2;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_e;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int N_PAIRS    = 2,
  parameter int ADDR_W     = 3,
  parameter int RST_PERIOD = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [CNT_W-1:0]                     wr_data,
  input  logic                                 load_full,
  input  logic                                 load_duty,
  output logic [CB_COMP0+N_PAIRS-1:0]          act_ctrl,
  output logic [CNT_W-1:0]                     act_period,
  output logic [2*N_PAIRS-1:0][CNT_W-1:0]      act_duty
);
  localparam int N_OUT  = 2 * N_PAIRS;
  localparam int CTRL_W = CB_COMP0 + N_PAIRS;

  logic [CTRL_W-1:0]            sh_ctrl;
  logic [CNT_W-1:0]             sh_period;
  logic [N_OUT-1:0][CNT_W-1:0]  sh_duty;
  logic                         hit_ctrl, hit_period;
  logic [N_OUT-1:0]             hit_duty;

  assign hit_ctrl   = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign hit_period = wr_en && (wr_addr == ADDR_W'(A_PERIOD));

  for (genvar i = 0; i < N_OUT; i++) begin : g_hit
    assign hit_duty[i] = wr_en && (wr_addr == ADDR_W'(A_DUTY0 + i));
  end

  // staging copies
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ctrl   <= '0;
      sh_period <= CNT_W'(RST_PERIOD);
      sh_duty   <= '0;
    end else begin
      if (hit_ctrl) sh_ctrl <= wr_data[CTRL_W-1:0];
      if (hit_period)
        sh_period <= (wr_data < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : wr_data;
      for (int i = 0; i < N_OUT; i++)
        if (hit_duty[i]) sh_duty[i] <= wr_data;
    end
  end

  // active copies, loaded at reload points
  always_ff @(posedge clk) begin
    if (rst) begin
      act_ctrl   <= '0;
      act_period <= CNT_W'(RST_PERIOD);
      act_duty   <= '0;
    end else begin
      if (load_full) begin
        act_ctrl   <= sh_ctrl;
        act_period <= sh_period;
      end
      if (load_full || load_duty) act_duty <= sh_duty;
    end
  end

  p_period_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_full |=> $stable(act_period));
  p_duty_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(load_full || load_duty) |=> $stable(act_duty));
  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (load_duty && !load_full) |=> $stable(act_ctrl) && $stable(act_period));
  p_period_min_r11: assert property (@(posedge clk) disable iff (rst)
    act_period >= CNT_W'(MIN_PERIOD));
endmodule

// File: rtl/pwm_quad_timebase.sv
module pwm_quad_timebase
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             center,
  input  logic             dbl,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             load_full,
  output logic             load_duty,
  output logic             sync
);
  cnt_dir_e         dir;
  logic             at_start, at_mid;
  logic [CNT_W-1:0] cnt_inc, top_m1;

  assign cnt_inc = cnt + CNT_W'(1);
  assign top_m1  = period - CNT_W'(1);

  always_comb begin
    at_start = en && (center ? (dir == DIR_DOWN && cnt == CNT_W'(1)) : (cnt == top_m1));
    at_mid   = en && center && dbl && (dir == DIR_UP) && (cnt == top_m1);
  end

  assign load_full = at_start || !en;
  assign load_duty = at_mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      dir  <= DIR_UP;
      sync <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      dir  <= DIR_UP;
      sync <= 1'b0;
    end else begin
      sync <= at_start || at_mid;
      if (at_start) begin
        cnt <= '0;
        dir <= DIR_UP;
      end else if (center) begin
        if (dir == DIR_UP) begin
          cnt <= cnt_inc;
          if (cnt_inc == period) dir <= DIR_DOWN;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end else begin
        cnt <= cnt_inc;
      end
    end
  end

  p_cnt_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !center) |-> cnt < period);
  p_cnt_center_r3: assert property (@(posedge clk) disable iff (rst)
    center |-> cnt <= period);
  p_sync_single_r9: assert property (@(posedge clk) disable iff (rst)
    sync |=> !sync);
  p_hold_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);
endmodule

// File: rtl/pwm_quad_outstage.sv
module pwm_quad_outstage #(
  parameter int CNT_W   = 16,
  parameter int N_PAIRS = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            en,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [CNT_W-1:0]                period,
  input  logic [2*N_PAIRS-1:0][CNT_W-1:0] duty,
  input  logic [N_PAIRS-1:0]              comp,
  output logic [2*N_PAIRS-1:0]            pwm
);
  localparam int N_OUT = 2 * N_PAIRS;

  logic [N_OUT-1:0] raw, nxt;

  for (genvar i = 0; i < N_OUT; i++) begin : g_cmp
    assign raw[i] = (duty[i] != '0) && ((duty[i] >= period) || (cnt < duty[i]));
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    assign nxt[2*p]   = raw[2*p];
    assign nxt[2*p+1] = comp[p] ? !raw[2*p] : raw[2*p+1];

    p_comp_pair_r4: assert property (@(posedge clk) disable iff (rst)
      $past(en && comp[p]) |-> (pwm[2*p+1] == !pwm[2*p]));
  end

  always_ff @(posedge clk) begin
    if (rst) pwm <= '0;
    else     pwm <= en ? nxt : '0;
  end

  p_zero_duty_r6: assert property (@(posedge clk) disable iff (rst)
    $past(en && duty[0] == '0) |-> !pwm[0]);
  p_full_duty_r6: assert property (@(posedge clk) disable iff (rst)
    $past(en && duty[0] >= period) |-> pwm[0]);
endmodule

// File: rtl/pwm_quad_gen.sv
module pwm_quad_gen
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int N_PAIRS    = 2,
  parameter int ADDR_W     = 3,
  parameter int RST_PERIOD = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  output logic [2*N_PAIRS-1:0]   pwm_out,
  output logic                   sync_pulse
);
  localparam int N_OUT  = 2 * N_PAIRS;
  localparam int CTRL_W = CB_COMP0 + N_PAIRS;

  logic [CTRL_W-1:0]           act_ctrl;
  logic [CNT_W-1:0]            act_period;
  logic [N_OUT-1:0][CNT_W-1:0] act_duty;
  logic [CNT_W-1:0]            cnt;
  logic                        load_full, load_duty;

  pwm_quad_regs #(
    .CNT_W(CNT_W), .N_PAIRS(N_PAIRS), .ADDR_W(ADDR_W), .RST_PERIOD(RST_PERIOD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_full(load_full), .load_duty(load_duty),
    .act_ctrl(act_ctrl), .act_period(act_period), .act_duty(act_duty)
  );

  pwm_quad_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .en(en),
    .center(act_ctrl[CB_CENTER]), .dbl(act_ctrl[CB_DOUBLE]), .period(act_period),
    .cnt(cnt), .load_full(load_full), .load_duty(load_duty), .sync(sync_pulse)
  );

  pwm_quad_outstage #(.CNT_W(CNT_W), .N_PAIRS(N_PAIRS)) u_out (
    .clk(clk), .rst(rst), .en(en), .cnt(cnt), .period(act_period),
    .duty(act_duty), .comp(act_ctrl[CTRL_W-1:CB_COMP0]), .pwm(pwm_out)
  );

  p_disabled_low_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm_out == '0) && !sync_pulse);
endmodule

// File: tb/pwm_quad_gen_bench.sv
module pwm_quad_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm_out;
  logic        sync_pulse;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit chk_on = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_quad_gen u_pwm_quad_gen (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .sync_pulse(sync_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-stepped model built from the requirements
  int m_sh_ctrl, m_sh_per, m_ctrl, m_per, m_cnt;
  int m_sh_d[4];
  int m_d[4];
  bit m_down, m_sync;
  bit [3:0] m_out;

  always @(posedge clk) begin
    bit [3:0] raw;
    bit st, md, ctr, dbl;
    if (rst) begin
      m_sh_ctrl = 0; m_ctrl = 0; m_sh_per = 16; m_per = 16; m_cnt = 0;
      for (int i = 0; i < 4; i++) begin m_sh_d[i] = 0; m_d[i] = 0; end
      m_down = 0; m_sync = 0; m_out = '0;
    end else begin
      if (!en) begin
        m_out = '0; m_sync = 0; m_cnt = 0; m_down = 0;
        m_ctrl = m_sh_ctrl; m_per = m_sh_per; m_d = m_sh_d;
      end else begin
        for (int i = 0; i < 4; i++)
          raw[i] = (m_d[i] != 0) && (m_d[i] >= m_per || m_cnt < m_d[i]);
        m_out[0] = raw[0];
        m_out[1] = m_ctrl[2] ? !raw[0] : raw[1];
        m_out[2] = raw[2];
        m_out[3] = m_ctrl[3] ? !raw[2] : raw[3];
        ctr = m_ctrl[0]; dbl = m_ctrl[1];
        st = ctr ? (m_down && m_cnt == 1) : (m_cnt == m_per - 1);
        md = ctr && dbl && !m_down && m_cnt == m_per - 1;
        m_sync = st || md;
        if (st) begin
          m_cnt = 0; m_down = 0;
          m_ctrl = m_sh_ctrl; m_per = m_sh_per; m_d = m_sh_d;
        end else if (ctr) begin
          if (!m_down) begin
            m_cnt++;
            if (m_cnt == m_per) m_down = 1;
          end else m_cnt--;
        end else m_cnt++;
        if (md) m_d = m_sh_d;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_sh_ctrl = int'(wr_data[3:0]);
          3'd1: m_sh_per = (wr_data < 2) ? 2 : int'(wr_data);
          3'd2, 3'd3, 3'd4, 3'd5: m_sh_d[wr_addr - 2] = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && chk_on) begin
      check(pwm_out == m_out, cur_req, pwm_out, m_out);
      check(sync_pulse == m_sync, cur_req, sync_pulse, m_sync);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_sync();
    @(negedge clk);
    while (!sync_pulse) @(negedge clk);
  endtask

  // count high samples per output over len cycles after a sync
  task automatic measure(input int len, output int hi[4], output int syncs);
    for (int i = 0; i < 4; i++) hi[i] = 0;
    syncs = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) hi[i] += int'(pwm_out[i]);
      syncs += int'(sync_pulse);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hi[4];
    int ns;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(pwm_out == 4'b0, "R1", pwm_out, 0);
    check(sync_pulse == 1'b0, "R1", sync_pulse, 0);
    rst = 1'b0;
    chk_on = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm_out == 4'b0, "R1", pwm_out, 0);

    // program while disabled, edge mode, independent duties
    cur_req = "R10";
    wr(0, 0); wr(1, 10); wr(2, 3); wr(3, 0); wr(4, 10); wr(5, 7);
    repeat (3) @(negedge clk);
    check(pwm_out == 4'b0 && !sync_pulse, "R10", pwm_out, 0);
    @(negedge clk); en = 1'b1;
    cur_req = "R2";
    wait_sync();
    measure(10, hi, ns);
    check(hi[0] == 3, "R2", hi[0], 3);
    check(hi[3] == 7, "R5", hi[3], 7);
    check(hi[1] == 0, "R6", hi[1], 0);
    check(hi[2] == 10, "R6", hi[2], 10);
    check(ns == 1, "R9", ns, 1);

    // R7 shadowing: write mid-period, no change until reload
    cur_req = "R7";
    wait_sync();
    for (int k = 0; k < 4; k++) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd8;
    @(negedge clk); wr_en = 1'b0;
    wr(6, 5); wr(7, 9);
    while (!sync_pulse) @(negedge clk);
    measure(10, hi, ns);
    check(hi[0] == 8, "R7", hi[0], 8);
    check(hi[1] == 0 && hi[3] == 7, "R7", hi[1] + hi[3], 7);

    // R4 complementary pair 0; duty of output 1 ignored
    cur_req = "R4";
    wr(3, 2); wr(0, 4);
    wait_sync();
    hi[1] = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(pwm_out[1] == !pwm_out[0], "R4", pwm_out[1], !pwm_out[0]);
      hi[1] += int'(pwm_out[1]);
    end
    check(hi[1] == 2, "R4", hi[1], 2);

    // R3 center single update
    cur_req = "R3";
    wr(1, 6); wr(2, 2); wr(3, 4); wr(4, 6); wr(5, 0); wr(0, 1);
    wait_sync();
    measure(12, hi, ns);
    check(hi[0] == 3, "R3", hi[0], 3);
    check(hi[1] == 7, "R3", hi[1], 7);
    check(hi[2] == 12, "R6", hi[2], 12);
    check(hi[3] == 0, "R6", hi[3], 0);
    check(ns == 1, "R8", ns, 1);

    // R8 double update
    cur_req = "R8";
    wr(0, 3);
    wait_sync();
    measure(24, hi, ns);
    check(ns == 4, "R8", ns, 4);
    wr(2, 5);
    measure(24, hi, ns);
    check(ns == 4, "R8", ns, 4);

    // R11 period below 2
    cur_req = "R11";
    wr(0, 0); wr(1, 1); wr(2, 1);
    wait_sync();
    wait_sync();
    measure(8, hi, ns);
    check(ns == 4, "R11", ns, 4);
    check(hi[0] == 4, "R11", hi[0], 4);

    // R10 disable
    cur_req = "R10";
    @(negedge clk); en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(pwm_out == 4'b0 && !sync_pulse, "R10", pwm_out, 0);
    end
    @(negedge clk); en = 1'b1;

    // random mix, model checked every cycle
    cur_req = "R5";
    void'($urandom(32'd1234));
    for (int r = 0; r < 60; r++) begin
      int a;
      a = int'($urandom_range(0, 7));
      case (a)
        0: wr(0, int'($urandom_range(0, 15)));
        1: wr(1, int'($urandom_range(1, 12)));
        default: wr(a, int'($urandom_range(0, 14)));
      endcase
      if ($urandom_range(0, 9) == 0) begin
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
      end
      repeat ($urandom_range(1, 40)) @(negedge clk);
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule